// File: doc/BRIEF.md
# Signed Q8.24 Correction Datapath

This block evaluates a fixed correction expression on signed fixed-point numbers: the result is `b + k*(a - (2*b + c))`. Every operand and the result are 32-bit two's-complement values with 24 fractional bits and 8 integer bits, sign included. The block suits any place where a base value is adjusted by a scaled signed error term, with `k` acting as the gain. For example, `k` can be 0.2, encoded as `0x00333333`.

Each operand set is presented with a one-cycle valid strobe. The block has three register stages: difference, multiply with rescale, then add with saturation. It accepts a new operand set on every clock. The signed difference and the scaled term are kept at full width, so no wrap happens before the last step. Saturation is applied once, to the final sum, and a sticky flag records that it happened.

Top module: `fxp_corr_top`

## Requirements
- R1: All values are two's complement. A real value v is encoded as the integer v*2^24 in 32 bits (2.0 is `0x02000000`). The output is `b + k*(a - 2*b - c)`, where `2*b` is an arithmetic left shift by one. The difference and the scaled term are carried without wrap, so an intermediate outside the 32-bit range still gives an exact result when the final sum fits. For example, a=`0x80000000`, b=`0x80000000`, c=`0x88000000`, k=`0x01000000` gives `0x78000000`.
- R2: The product is scaled down by 2^24 and rounded to the nearest LSB, with exact ties going to the even value. For example, with b=c=0 and k=`0x00800000`: a=1 gives 0, a=3 gives 2, a=-1 gives 0 and a=-3 gives -2, all in LSB units. Any non-saturating result is within one LSB of the real-valued expression.
- R3: a=`0x02000000`, b=`0x03000000`, c=`0x04000000`, k=`0x00333333` gives `0x01666668`, which is 1.4 to within the quantisation of k.
- R4: If the scaled term drives the sum above the maximum, y_out is `0x7FFFFFFF`. If it drives the sum below the minimum, y_out is `0x80000000`. In both cases ovf_sticky is set.
- R5: If the scaled term is in range but adding b leaves the range, y_out saturates in the same way and ovf_sticky is set.
- R6: Once set, ovf_sticky stays high through later in-range results until reset.
- R7: out_valid rises exactly three clocks after in_valid. An operand set may be presented every clock, and the results come out in the order the operands went in.
- R8: While in_valid is low, out_valid stays low, y_out keeps its last value and ovf_sticky does not change, whatever the operand inputs carry.
- R9: A synchronous active-high reset clears out_valid and ovf_sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on a_in..k_in are valid this cycle |
| a_in | input | 32 | Operand a, signed Q8.24 |
| b_in | input | 32 | Operand b (the base value), signed Q8.24 |
| c_in | input | 32 | Operand c, signed Q8.24 |
| k_in | input | 32 | Gain k, signed Q8.24 |
| out_valid | output | 1 | y_out holds a new result this cycle |
| y_out | output | 32 | Saturated result, signed Q8.24 |
| ovf_sticky | output | 1 | Some result has saturated since reset |

## Verification
Each of the three valid bits depends only on the one before it. A dropped or duplicated valid bit therefore shows at out_valid in the exact cycle three clocks after the strobe, and results that follow arrive out of order.

A wrong sign extension, shift or rounding choice in the first two stages reaches y_out with that same result. The tie vectors and the out-of-range intermediate vector expose such errors down to a single LSB.

A flaw in the saturation or sticky logic shows on the first out-of-range result. It also shows on every in-range result after it, as a flag that drops too early or a value that is clipped when it should not be.

// File: rtl/fxp_corr_pkg.sv
package fxp_corr_pkg;
    // Default word and fraction widths of the signed fixed-point format
    localparam int unsigned DATA_W = 32;
    localparam int unsigned FRAC_W = 24;
    // Register stages from operand strobe to result
    localparam int unsigned PIPE_DEPTH = 3;
endpackage

// File: rtl/fxp_diff_stage.sv
// Stage 1: exact signed difference a - 2b - c, two guard bits wide.
module fxp_diff_stage #(
    parameter int W = fxp_corr_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         v_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    input  logic [W-1:0] k_i,
    output logic         v_o,
    output logic [W+1:0] d_o,
    output logic [W-1:0] b_o,
    output logic [W-1:0] k_o
);
    localparam int DW = W + 2;

    typedef struct packed {
        logic          v;
        logic [DW-1:0] d;
        logic [W-1:0]  b;
        logic [W-1:0]  k;
    } diff_st_t;

    diff_st_t st_d, st_q;

    logic [DW-1:0] a_x;
    logic [DW-1:0] b_x2;
    logic [DW-1:0] c_x;

    always_comb begin
        a_x  = {{2{a_i[W-1]}}, a_i};
        b_x2 = {b_i[W-1], b_i, 1'b0};
        c_x  = {{2{c_i[W-1]}}, c_i};
        st_d   = st_q;
        st_d.v = v_i;
        if (v_i) begin
            st_d.d = a_x - b_x2 - c_x;
            st_d.b = b_i;
            st_d.k = k_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign v_o = st_q.v;
    assign d_o = st_q.d;
    assign b_o = st_q.b;
    assign k_o = st_q.k;

    // R1: zero operands must produce a zero difference
    p_diff_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (v_i && a_i == '0 && b_i == '0 && c_i == '0) |=> (d_o == '0));
endmodule

// File: rtl/fxp_scale_stage.sv
// Stage 2: full-width signed product, rescaled with round-to-nearest-even.
module fxp_scale_stage #(
    parameter int W = fxp_corr_pkg::DATA_W,
    parameter int F = fxp_corr_pkg::FRAC_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 v_i,
    input  logic [W+1:0]         d_i,
    input  logic [W-1:0]         k_i,
    input  logic [W-1:0]         b_i,
    output logic                 v_o,
    output logic [2*W+1-F:0]     term_o,
    output logic [W-1:0]         b_o
);
    localparam int DW = W + 2;
    localparam int PW = DW + W;
    localparam int TW = PW - F;

    typedef struct packed {
        logic          v;
        logic [TW-1:0] term;
        logic [W-1:0]  b;
    } scale_st_t;

    scale_st_t st_d, st_q;

    logic [PW-1:0] d_x;
    logic [PW-1:0] k_x;
    logic [PW-1:0] prod;
    logic [TW-1:0] hi;
    logic          guard;
    logic          sticky;
    logic          bump;

    always_comb begin
        d_x    = {{W{d_i[DW-1]}}, d_i};
        k_x    = {{DW{k_i[W-1]}}, k_i};
        prod   = $signed(d_x) * $signed(k_x);
        hi     = prod[PW-1:F];
        guard  = prod[F-1];
        sticky = |prod[F-2:0];
        bump   = guard & (sticky | hi[0]);
        st_d   = st_q;
        st_d.v = v_i;
        if (v_i) begin
            st_d.term = hi + {{(TW-1){1'b0}}, bump};
            st_d.b    = b_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign v_o    = st_q.v;
    assign term_o = st_q.term;
    assign b_o    = st_q.b;

    // R2: operands of equal sign can never round to a negative term
    p_term_sign_r2: assert property (@(posedge clk) disable iff (rst)
        (v_i && (d_i[DW-1] == k_i[W-1])) |=> !term_o[TW-1]);
endmodule

// File: rtl/fxp_sat_add_stage.sv
// Stage 3: add base value, saturate once, keep a sticky overflow flag.
module fxp_sat_add_stage #(
    parameter int W  = fxp_corr_pkg::DATA_W,
    parameter int TW = 2 * fxp_corr_pkg::DATA_W + 2 - fxp_corr_pkg::FRAC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          v_i,
    input  logic [TW-1:0] term_i,
    input  logic [W-1:0]  b_i,
    output logic          v_o,
    output logic [W-1:0]  y_o,
    output logic          ovf_o
);
    localparam int SW = TW + 1;
    localparam logic [W-1:0] Y_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] Y_MIN = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic         v;
        logic [W-1:0] y;
        logic         ovf;
    } add_st_t;

    add_st_t st_d, st_q;

    logic [SW-1:0] sum;
    logic          fits;
    logic          hi_clip;
    logic          lo_clip;
    logic [W-1:0]  y_sat;

    always_comb begin
        sum     = {term_i[TW-1], term_i} + {{(SW-W){b_i[W-1]}}, b_i};
        fits    = (&sum[SW-1:W-1]) | ~(|sum[SW-1:W-1]);
        hi_clip = !fits && !sum[SW-1];
        lo_clip = !fits &&  sum[SW-1];
        if (hi_clip)      y_sat = Y_MAX;
        else if (lo_clip) y_sat = Y_MIN;
        else              y_sat = sum[W-1:0];
        st_d   = st_q;
        st_d.v = v_i;
        if (v_i) begin
            st_d.y   = y_sat;
            st_d.ovf = st_q.ovf | hi_clip | lo_clip;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign v_o   = st_q.v;
    assign y_o   = st_q.y;
    assign ovf_o = st_q.ovf;

    // R6: the overflow flag never drops without reset
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        st_q.ovf |=> st_q.ovf);
    // R5: two non-negative addends never give a negative result
    p_pos_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (v_i && !term_i[TW-1] && !b_i[W-1]) |=> !y_o[W-1]);
    // R5: two negative addends never give a non-negative result
    p_neg_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (v_i && term_i[TW-1] && b_i[W-1]) |=> y_o[W-1]);
    // R8: no strobe, no change of result or flag
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !v_i |=> ($stable(y_o) && $stable(ovf_o)));
endmodule

// File: rtl/fxp_corr_top.sv
// y = b + k*(a - (2b + c)) in signed fixed point, three register stages.
module fxp_corr_top #(
    parameter int W = fxp_corr_pkg::DATA_W,
    parameter int F = fxp_corr_pkg::FRAC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] c_in,
    input  logic [W-1:0] k_in,
    output logic         out_valid,
    output logic [W-1:0] y_out,
    output logic         ovf_sticky
);
    localparam int DW = W + 2;
    localparam int TW = DW + W - F;

    logic          v1;
    logic [DW-1:0] d1;
    logic [W-1:0]  b1;
    logic [W-1:0]  k1;
    logic          v2;
    logic [TW-1:0] term2;
    logic [W-1:0]  b2;

    fxp_diff_stage #(.W(W)) u_diff (
        .clk (clk),
        .rst (rst),
        .v_i (in_valid),
        .a_i (a_in),
        .b_i (b_in),
        .c_i (c_in),
        .k_i (k_in),
        .v_o (v1),
        .d_o (d1),
        .b_o (b1),
        .k_o (k1)
    );

    fxp_scale_stage #(.W(W), .F(F)) u_scale (
        .clk    (clk),
        .rst    (rst),
        .v_i    (v1),
        .d_i    (d1),
        .k_i    (k1),
        .b_i    (b1),
        .v_o    (v2),
        .term_o (term2),
        .b_o    (b2)
    );

    fxp_sat_add_stage #(.W(W), .TW(TW)) u_add (
        .clk    (clk),
        .rst    (rst),
        .v_i    (v2),
        .term_i (term2),
        .b_i    (b2),
        .v_o    (out_valid),
        .y_o    (y_out),
        .ovf_o  (ovf_sticky)
    );

    // R7: each strobe advances one stage per clock
    p_chain_in_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> v1);
    p_chain_mid_r7: assert property (@(posedge clk) disable iff (rst)
        v1 |=> v2);
    p_chain_out_r7: assert property (@(posedge clk) disable iff (rst)
        v2 |=> out_valid);
endmodule

// File: tb/test_fxp_corr_top.sv
module test_fxp_corr_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] a_in = '0;
    logic [31:0] b_in = '0;
    logic [31:0] c_in = '0;
    logic [31:0] k_in = '0;
    logic        out_valid;
    logic [31:0] y_out;
    logic        ovf_sticky;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fxp_corr_top i_fxp_corr_top (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .a_in       (a_in),
        .b_in       (b_in),
        .c_in       (c_in),
        .k_in       (k_in),
        .out_valid  (out_valid),
        .y_out      (y_out),
        .ovf_sticky (ovf_sticky)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Real-valued reference in LSB units, clamped to the 32-bit range
    function automatic real model(logic [31:0] a, logic [31:0] b,
                                  logic [31:0] c, logic [31:0] k);
        real d, y;
        d = $itor($signed(a)) - 2.0 * $itor($signed(b)) - $itor($signed(c));
        y = $itor($signed(b)) + $itor($signed(k)) * d / 16777216.0;
        if (y > 2147483647.0)  y = 2147483647.0;
        if (y < -2147483648.0) y = -2147483648.0;
        return y;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", "out_valid after reset", {31'd0, out_valid}, 32'd0);
        chk(ovf_sticky == 1'b0, "R9", "ovf after reset", {31'd0, ovf_sticky}, 32'd0);
    endtask

    // One operand set, latency checked, result returned
    task automatic run_one(input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] c, input logic [31:0] k,
                           output logic [31:0] y, output logic ovf);
        @(negedge clk);
        a_in = a; b_in = b; c_in = c; k_in = k;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R7", "early valid +1", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", "early valid +2", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R7", "valid at +3", {31'd0, out_valid}, 32'd1);
        y   = y_out;
        ovf = ovf_sticky;
    endtask

    task automatic t_example();
        logic [31:0] y; logic o;
        run_one(32'h0200_0000, 32'h0300_0000, 32'h0400_0000, 32'h0033_3333, y, o);
        chk(y == 32'h0166_6668, "R3", "1.4 example", y, 32'h0166_6668);
        chk(o == 1'b0, "R3", "no ovf on example", {31'd0, o}, 32'd0);
    endtask

    task automatic t_zero();
        logic [31:0] y; logic o;
        run_one('0, '0, '0, 32'h0033_3333, y, o);
        chk(y == 32'd0, "R1", "all-zero operands", y, 32'd0);
    endtask

    task automatic t_ties();
        logic [31:0] y; logic o;
        run_one(32'd1, '0, '0, 32'h0080_0000, y, o);
        chk(y == 32'd0, "R2", "tie +0.5 to even", y, 32'd0);
        run_one(32'd3, '0, '0, 32'h0080_0000, y, o);
        chk(y == 32'd2, "R2", "tie +1.5 to even", y, 32'd2);
        run_one(32'hFFFF_FFFF, '0, '0, 32'h0080_0000, y, o);
        chk(y == 32'd0, "R2", "tie -0.5 to even", y, 32'd0);
        run_one(32'hFFFF_FFFD, '0, '0, 32'h0080_0000, y, o);
        chk(y == 32'hFFFF_FFFE, "R2", "tie -1.5 to even", y, 32'hFFFF_FFFE);
    endtask

    task automatic t_wide_mid();
        logic [31:0] y; logic o;
        run_one(32'h8000_0000, 32'h8000_0000, 32'h8800_0000, 32'h0100_0000, y, o);
        chk(y == 32'h7800_0000, "R1", "wide intermediate exact", y, 32'h7800_0000);
        chk(o == 1'b0, "R1", "no ovf for wide intermediate", {31'd0, o}, 32'd0);
    endtask

    task automatic t_idle();
        logic [31:0] y0;
        y0 = y_out;
        a_in = 32'h7F00_0000; b_in = '0; c_in = '0; k_in = 32'h7F00_0000;
        in_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R8", "no valid while idle", {31'd0, out_valid}, 32'd0);
            chk(y_out == y0, "R8", "y holds while idle", y_out, y0);
            chk(ovf_sticky == 1'b0, "R8", "ovf unchanged while idle", {31'd0, ovf_sticky}, 32'd0);
        end
    endtask

    task automatic t_random();
        logic [31:0] a, b, c, k, y; logic o; real e, df;
        for (int i = 0; i < 20; i++) begin
            a = $signed(32'($urandom)) >>> 4;
            b = $signed(32'($urandom)) >>> 4;
            c = $signed(32'($urandom)) >>> 4;
            k = $signed(32'($urandom)) >>> 7;
            run_one(a, b, c, k, y, o);
            e  = model(a, b, c, k);
            df = $itor($signed(y)) - e;
            chk(df <= 1.0 && df >= -1.0, "R2", "random vs real model", y, 32'($rtoi(e)));
        end
    endtask

    task automatic t_stream();
        logic [31:0] sa[8], sb[8], sc[8], sk[8];
        real e, df;
        for (int i = 0; i < 8; i++) begin
            sa[i] = $signed(32'($urandom)) >>> 4;
            sb[i] = $signed(32'($urandom)) >>> 4;
            sc[i] = $signed(32'($urandom)) >>> 4;
            sk[i] = $signed(32'($urandom)) >>> 7;
        end
        for (int t = 0; t < 11; t++) begin
            @(negedge clk);
            if (t >= 3) begin
                e  = model(sa[t-3], sb[t-3], sc[t-3], sk[t-3]);
                df = $itor($signed(y_out)) - e;
                chk(out_valid == 1'b1, "R7", "stream valid", {31'd0, out_valid}, 32'd1);
                chk(df <= 1.0 && df >= -1.0, "R7", "stream order/value", y_out, 32'($rtoi(e)));
            end else begin
                chk(out_valid == 1'b0, "R7", "stream fill", {31'd0, out_valid}, 32'd0);
            end
            if (t < 8) begin
                a_in = sa[t]; b_in = sb[t]; c_in = sc[t]; k_in = sk[t];
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", "stream drain", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_term_sat();
        logic [31:0] y; logic o;
        run_one(32'h7F00_0000, '0, '0, 32'h7F00_0000, y, o);
        chk(y == 32'h7FFF_FFFF, "R4", "positive saturation", y, 32'h7FFF_FFFF);
        chk(o == 1'b1, "R4", "ovf on positive saturation", {31'd0, o}, 32'd1);
        run_one(32'h0200_0000, 32'h0300_0000, 32'h0400_0000, 32'h0033_3333, y, o);
        chk(y == 32'h0166_6668, "R6", "in-range after saturation", y, 32'h0166_6668);
        chk(o == 1'b1, "R6", "ovf stays set", {31'd0, o}, 32'd1);
        do_reset();
        run_one(32'h8000_0000, '0, '0, 32'h7F00_0000, y, o);
        chk(y == 32'h8000_0000, "R4", "negative saturation", y, 32'h8000_0000);
        chk(o == 1'b1, "R4", "ovf on negative saturation", {31'd0, o}, 32'd1);
    endtask

    task automatic t_sum_sat();
        logic [31:0] y; logic o;
        do_reset();
        run_one(32'h7F00_0000, 32'h6400_0000, 32'h8000_0000, 32'h0100_0000, y, o);
        chk(y == 32'h7FFF_FFFF, "R5", "sum above range", y, 32'h7FFF_FFFF);
        chk(o == 1'b1, "R5", "ovf on sum above", {31'd0, o}, 32'd1);
        do_reset();
        run_one(32'h8000_0000, 32'h9C00_0000, 32'h7F00_0000, 32'h0100_0000, y, o);
        chk(y == 32'h8000_0000, "R5", "sum below range", y, 32'h8000_0000);
        chk(o == 1'b1, "R5", "ovf on sum below", {31'd0, o}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_example();
        t_zero();
        t_ties();
        t_wide_mid();
        t_idle();
        t_random();
        t_stream();
        t_term_sat();
        t_sum_sat();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule